// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

The block watches the control pins of a synchronous DRAM interface on every rising clock edge. It turns the chip select, the three strobes (row, column, write), clock enable, bank address and the precharge-option address bit into one registered command code. It flags a command as illegal when it does not fit the current state of the banks. It also keeps, for each of four banks, whether a row is open and which row that is.

The precharge-option bit has two meanings. On a read or write it asks for the bank to close on its own once the burst ends. On a precharge it widens the close to every bank. Clock enable is tracked as well. A low sample suspends the next cycle. A refresh encoding that is sampled with clock enable low puts the device into self-refresh, and it stays there until clock enable is high again.

All outputs are registered. A command sampled at a rising edge shows on `cmd_code` and `cmd_illegal` just after that edge, together with the bank state it leaves behind. An illegal command changes no bank state.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With clocking active and not in self-refresh, chip select high gives code 1 (deselect) whatever the strobes are, and no bank changes.
- R2: Activate (row strobe low, column and write strobes high) gives code 2. On an idle bank it opens that bank with the 12-bit row from `addr`. On an already open bank it sets `cmd_illegal` and leaves the open row as it was.
- R3: With column strobe low and row strobe high, write strobe high is a read (code 3, or 4 with `addr[10]` high) and write strobe low is a write (code 5, or 6 with `addr[10]` high). Either one is illegal when the bank is idle or has an automatic close pending.
- R4: A legal read or write with `addr[10]` high keeps the bank open and closes it at the BURST_LEN-th clock edge after the command, counting only edges whose cycle is not suspended.
- R5: Precharge (row and write strobes low, column strobe high) with `addr[10]` low gives code 7 and closes only the addressed bank. With `addr[10]` high it gives code 8 and closes all banks.
- R6: Refresh (row and column strobes low, write strobe and clock enable high) gives code 9. It is legal only when every bank is idle, and all banks are idle afterwards.
- R7: The refresh encoding sampled with clock enable low gives code 10. When all banks are idle it sets `self_refresh`. While clock enable stays low, every command gives code 14 and is ignored. The first edge with clock enable high gives code 11 and clears `self_refresh`.
- R8: Burst terminate (write strobe low, row and column strobes high) gives code 12. Mode register set (all strobes low) gives code 13. It is illegal when the bank bits or `addr[10]` are nonzero, or when any bank is open.
- R9: When clock enable was sampled low at the previous edge (self-refresh aside), the current command gives code 14 and the bank state, including any pending close countdown, is frozen. The first edge after reset counts as such a cycle.
- R10: During reset the outputs show code 0 (no operation), no illegal flag, all banks idle and `self_refresh` low. All strobes high with chip select low also gives code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row address; bit 10 is the precharge option |
| cmd_code | output | 4 | Registered decoded command code |
| cmd_illegal | output | 1 | Registered illegal-command flag |
| bank_open | output | 4 | One bit per bank, high when a row is open |
| bank_row | output | 48 | Open row per bank, bank n in bits 12n+11..12n |
| self_refresh | output | 1 | High while in self-refresh |

## Verification
The stimulus walks every strobe encoding both against idle banks and against open banks. This separates the decode from the legality check. For example, an activate on an open bank must keep its old row, and a read after an automatic close has been requested must be refused. Precharge is sent once with the option bit low and once with it high, to show a single close apart from an all-bank close. An automatic close is timed once with a running clock and once with a suspended cycle inside the countdown, which shows whether the countdown freezes. Self-refresh is tried once while a bank is open, where entry must be refused, and once with all banks idle, where commands given during self-refresh must leave the banks untouched.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [3:0] {
    CMD_NOP      = 4'd0,
    CMD_DESEL    = 4'd1,
    CMD_ACT      = 4'd2,
    CMD_RD       = 4'd3,
    CMD_RD_AP    = 4'd4,
    CMD_WR       = 4'd5,
    CMD_WR_AP    = 4'd6,
    CMD_PRE      = 4'd7,
    CMD_PRE_ALL  = 4'd8,
    CMD_REF      = 4'd9,
    CMD_SR_ENTER = 4'd10,
    CMD_SR_EXIT  = 4'd11,
    CMD_TERM     = 4'd12,
    CMD_MODE     = 4'd13,
    CMD_SUSPEND  = 4'd14
  } cmd_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  input  logic ap_bit,
  output cmd_e raw_cmd
);

  always_comb begin
    raw_cmd = CMD_NOP;
    if (cs_n) begin
      raw_cmd = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111: raw_cmd = CMD_NOP;
        3'b011: raw_cmd = CMD_ACT;
        3'b101: raw_cmd = ap_bit ? CMD_RD_AP : CMD_RD;
        3'b100: raw_cmd = ap_bit ? CMD_WR_AP : CMD_WR;
        3'b010: raw_cmd = ap_bit ? CMD_PRE_ALL : CMD_PRE;
        3'b001: raw_cmd = cke ? CMD_REF : CMD_SR_ENTER;
        3'b110: raw_cmd = CMD_TERM;
        3'b000: raw_cmd = CMD_MODE;
        default: raw_cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_power_ctl.sv
module sdram_power_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic sr_enter,
  output logic cke_prev,
  output logic in_sr
);

  logic cke_prev_d;
  logic in_sr_d;

  always_comb begin
    cke_prev_d = cke;
    in_sr_d    = in_sr;
    if (in_sr) begin
      if (cke) in_sr_d = 1'b0;
    end else if (sr_enter) begin
      in_sr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev <= 1'b0;
      in_sr    <= 1'b0;
    end else begin
      cke_prev <= cke_prev_d;
      in_sr    <= in_sr_d;
    end
  end

  // R7: self-refresh holds while clock enable stays low, ends once it is high
  p_sr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sr && !cke) |=> in_sr);
  p_sr_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sr && cke) |=> !in_sr);

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W     = 12,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             do_open,
  input  logic             do_close,
  input  logic             do_ap,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_o,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);

  localparam int CNT_W = $clog2(BURST_LEN + 1);

  logic             open_d, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ROW_W-1:0] row_d;
  logic             row_en;

  always_comb begin
    open_d = open_o;
    pend_d = pend_o;
    cnt_d  = cnt_q;
    row_d  = row_o;
    row_en = 1'b0;
    if (tick) begin
      if (do_close) begin
        open_d = 1'b0;
        pend_d = 1'b0;
        cnt_d  = '0;
      end else if (do_open) begin
        open_d = 1'b1;
        row_d  = row_in;
        row_en = 1'b1;
      end else if (do_ap) begin
        pend_d = 1'b1;
        cnt_d  = CNT_W'(BURST_LEN);
      end else if (pend_o) begin
        if (cnt_q == CNT_W'(1)) begin
          open_d = 1'b0;
          pend_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      pend_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      open_o <= open_d;
      pend_o <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_o <= '0;
    end else if (row_en) begin
      row_o <= row_d;
    end
  end

  // R4: the last step of an automatic-close countdown leaves the bank idle
  p_ap_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend_o && cnt_q == CNT_W'(1) && !do_open) |=> !open_o);
  // R2: a bank only opens through an accepted activate
  p_open_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_o) |-> $past(do_open && tick));

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_cmd_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int ROW_W     = 12,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cs_n,
  input  logic                        ras_n,
  input  logic                        cas_n,
  input  logic                        we_n,
  input  logic                        cke,
  input  logic [BA_W-1:0]             ba,
  input  logic [ROW_W-1:0]            addr,
  output logic [3:0]                  cmd_code,
  output logic                        cmd_illegal,
  output logic [(1<<BA_W)-1:0]        bank_open,
  output logic [(1<<BA_W)*ROW_W-1:0]  bank_row,
  output logic                        self_refresh
);

  localparam int NB = 1 << BA_W;

  cmd_e          raw_cmd, cmd_d, cmd_q;
  logic          illegal_d, illegal_q;
  logic          cke_prev, in_sr, tick, suspended, sr_enter;
  logic [NB-1:0] pend, do_open, do_close, do_ap;
  logic          sel_open, sel_pend, any_open;

  sdram_cmd_decode u_decode (
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .cke     (cke),
    .ap_bit  (addr[AP_BIT]),
    .raw_cmd (raw_cmd)
  );

  sdram_power_ctl u_power (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .sr_enter (sr_enter),
    .cke_prev (cke_prev),
    .in_sr    (in_sr)
  );

  assign tick      = !in_sr && cke_prev;
  assign suspended = !in_sr && !cke_prev;
  assign sel_open  = bank_open[ba];
  assign sel_pend  = pend[ba];
  assign any_open  = |bank_open;

  always_comb begin
    if (in_sr)         cmd_d = cke ? CMD_SR_EXIT : CMD_SUSPEND;
    else if (!cke_prev) cmd_d = CMD_SUSPEND;
    else               cmd_d = raw_cmd;
  end

  always_comb begin
    illegal_d = 1'b0;
    if (tick) begin
      unique case (cmd_d)
        CMD_ACT:                   illegal_d = sel_open;
        CMD_RD, CMD_RD_AP,
        CMD_WR, CMD_WR_AP:         illegal_d = !sel_open || sel_pend;
        CMD_REF, CMD_SR_ENTER:     illegal_d = any_open;
        CMD_MODE:                  illegal_d = any_open || (ba != '0) || addr[AP_BIT];
        default:                   illegal_d = 1'b0;
      endcase
    end
  end

  assign sr_enter = tick && (cmd_d == CMD_SR_ENTER) && !illegal_d;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      do_open[i]  = tick && !illegal_d && (cmd_d == CMD_ACT) && (ba == BA_W'(i));
      do_ap[i]    = tick && !illegal_d && (cmd_d == CMD_RD_AP || cmd_d == CMD_WR_AP)
                    && (ba == BA_W'(i));
      do_close[i] = tick && ((cmd_d == CMD_PRE && ba == BA_W'(i)) || cmd_d == CMD_PRE_ALL);
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdram_bank_slot #(
      .ROW_W     (ROW_W),
      .BURST_LEN (BURST_LEN)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .do_open  (do_open[g]),
      .do_close (do_close[g]),
      .do_ap    (do_ap[g]),
      .row_in   (addr),
      .open_o   (bank_open[g]),
      .pend_o   (pend[g]),
      .row_o    (bank_row[g*ROW_W +: ROW_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= CMD_NOP;
      illegal_q <= 1'b0;
    end else begin
      cmd_q     <= cmd_d;
      illegal_q <= illegal_d;
    end
  end

  assign cmd_code     = cmd_q;
  assign cmd_illegal  = illegal_q;
  assign self_refresh = in_sr;

  // R1: deselect while clocking is active reports code 1
  p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sr && cke_prev && cs_n) |=> (cmd_code == CMD_DESEL));
  // R9: a suspended cycle leaves every bank untouched
  p_suspend_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |=> $stable(bank_open));
  // R5: all-bank precharge leaves nothing open
  p_prea_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_PRE_ALL) |-> (bank_open == '0));
  // R6: an accepted refresh finds and leaves every bank idle
  p_refresh_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_REF && !cmd_illegal) |-> (bank_open == '0));

endmodule

// File: tb/sdram_cmd_tracker_test.sv
module sdram_cmd_tracker_test;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    int    code;
    bit    ill;
    int    banks;
    bit    sr;
    bit    rchk;
    int    rbank;
    int    rval;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n, cke;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [3:0]  cmd_code;
  logic        cmd_illegal;
  logic [3:0]  bank_open;
  logic [47:0] bank_row;
  logic        self_refresh;

  int   checks   = 0;
  int   failures = 0;
  bit   done     = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_tracker uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .cke          (cke),
    .ba           (ba),
    .addr         (addr),
    .cmd_code     (cmd_code),
    .cmd_illegal  (cmd_illegal),
    .bank_open    (bank_open),
    .bank_row     (bank_row),
    .self_refresh (self_refresh)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Drives one command for the coming edge and queues its expected outcome.
  task automatic issue(input bit s, input bit r, input bit c, input bit w, input bit k,
                       input int b, input int a, input int ec, input bit ei,
                       input int eb, input bit esr, input bit rc, input int rb,
                       input int rv, input string tag);
    exp_t e;
    cs_n = s; ras_n = r; cas_n = c; we_n = w; cke = k;
    ba = 2'(b); addr = 12'(a);
    e.code = ec; e.ill = ei; e.banks = eb; e.sr = esr;
    e.rchk = rc; e.rbank = rb; e.rval = rv; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compares each result a quarter period after the edge.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(int'(cmd_code) == e.code, e.tag, "code", int'(cmd_code), e.code);
      check(cmd_illegal == e.ill, e.tag, "illegal", int'(cmd_illegal), int'(e.ill));
      check(int'(bank_open) == e.banks, e.tag, "banks", int'(bank_open), e.banks);
      check(self_refresh == e.sr, e.tag, "self_refresh", int'(self_refresh), int'(e.sr));
      if (e.rchk)
        check(int'(bank_row[e.rbank*12 +: 12]) == e.rval, e.tag, "row",
              int'(bank_row[e.rbank*12 +: 12]), e.rval);
    end
  end

  initial begin
    rst_n = 1'b0;
    cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; cke = 1'b1;
    ba = '0; addr = '0;
    repeat (3) @(negedge clk);
    check(cmd_code == 4'd0, "R10", "reset code", int'(cmd_code), 0);
    check(!cmd_illegal && bank_open == 4'd0 && !self_refresh, "R10", "reset state",
          int'({cmd_illegal, bank_open, self_refresh}), 0);
    rst_n = 1'b1;
    //      cs r  c  w  k  ba addr    code ill banks sr rchk rb rv
    issue(0, 1, 1, 1, 1, 0, 0,      14, 0, 4'b0000, 0, 0, 0, 0,     "R9 first edge after reset");
    issue(0, 1, 1, 1, 1, 0, 0,       0, 0, 4'b0000, 0, 0, 0, 0,     "R10 nop");
    issue(1, 0, 0, 0, 1, 1, 0,       1, 0, 4'b0000, 0, 0, 0, 0,     "R1 deselect");
    issue(0, 0, 1, 1, 1, 1, 'hABC,   2, 0, 4'b0010, 0, 1, 1, 'hABC, "R2 activate idle");
    issue(0, 0, 1, 1, 1, 1, 'h123,   2, 1, 4'b0010, 0, 1, 1, 'hABC, "R2 activate open");
    issue(0, 1, 0, 1, 1, 0, 0,       3, 1, 4'b0010, 0, 0, 0, 0,     "R3 read idle bank");
    issue(0, 1, 0, 0, 1, 1, 0,       5, 0, 4'b0010, 0, 0, 0, 0,     "R3 write open");
    issue(0, 1, 0, 1, 1, 1, 0,       3, 0, 4'b0010, 0, 0, 0, 0,     "R3 read open");
    issue(0, 0, 0, 1, 1, 0, 0,       9, 1, 4'b0010, 0, 0, 0, 0,     "R6 refresh with open bank");
    issue(0, 0, 1, 1, 1, 2, 'h055,   2, 0, 4'b0110, 0, 1, 2, 'h055, "R2 activate second");
    issue(0, 0, 1, 0, 1, 1, 0,       7, 0, 4'b0100, 0, 0, 0, 0,     "R5 single precharge");
    issue(0, 0, 1, 1, 1, 3, 'hFFF,   2, 0, 4'b1100, 0, 1, 3, 'hFFF, "R2 activate third");
    issue(0, 0, 1, 0, 1, 0, 'h400,   8, 0, 4'b0000, 0, 0, 0, 0,     "R5 precharge all");
    issue(0, 0, 0, 1, 1, 0, 0,       9, 0, 4'b0000, 0, 0, 0, 0,     "R6 refresh idle");
    issue(0, 0, 1, 1, 1, 0, 'h111,   2, 0, 4'b0001, 0, 0, 0, 0,     "R2 activate bank0");
    issue(0, 1, 0, 1, 1, 0, 'h400,   4, 0, 4'b0001, 0, 0, 0, 0,     "R4 read auto close");
    issue(0, 1, 1, 1, 1, 0, 0,       0, 0, 4'b0001, 0, 0, 0, 0,     "R4 countdown 1");
    issue(0, 1, 1, 1, 1, 0, 0,       0, 0, 4'b0001, 0, 0, 0, 0,     "R4 countdown 2");
    issue(0, 1, 0, 1, 1, 0, 0,       3, 1, 4'b0001, 0, 0, 0, 0,     "R3 read pending close");
    issue(0, 1, 1, 1, 1, 0, 0,       0, 0, 4'b0000, 0, 0, 0, 0,     "R4 bank closed");
    issue(0, 0, 1, 1, 1, 0, 'h222,   2, 0, 4'b0001, 0, 1, 0, 'h222, "R2 reopen bank0");
    issue(0, 1, 0, 0, 1, 0, 'h400,   6, 0, 4'b0001, 0, 0, 0, 0,     "R4 write auto close");
    issue(0, 1, 1, 1, 0, 0, 0,       0, 0, 4'b0001, 0, 0, 0, 0,     "R9 cke low sampled");
    issue(0, 0, 1, 1, 1, 1, 'h777,  14, 0, 4'b0001, 0, 0, 0, 0,     "R9 suspended activate");
    issue(0, 1, 1, 1, 1, 0, 0,       0, 0, 4'b0001, 0, 0, 0, 0,     "R9 countdown frozen");
    issue(0, 1, 1, 1, 1, 0, 0,       0, 0, 4'b0001, 0, 0, 0, 0,     "R4 countdown late");
    issue(0, 1, 1, 1, 1, 0, 0,       0, 0, 4'b0000, 0, 0, 0, 0,     "R4 closed after freeze");
    issue(0, 1, 1, 0, 1, 0, 0,      12, 0, 4'b0000, 0, 0, 0, 0,     "R8 burst terminate");
    issue(0, 0, 0, 0, 1, 0, 'h023,  13, 0, 4'b0000, 0, 0, 0, 0,     "R8 mode set");
    issue(0, 0, 0, 0, 1, 1, 'h023,  13, 1, 4'b0000, 0, 0, 0, 0,     "R8 mode set bad bank");
    issue(0, 0, 1, 1, 1, 2, 'h333,   2, 0, 4'b0100, 0, 0, 0, 0,     "R2 activate bank2");
    issue(0, 0, 0, 1, 0, 0, 0,      10, 1, 4'b0100, 0, 0, 0, 0,     "R7 entry refused");
    issue(0, 1, 1, 1, 1, 0, 0,      14, 0, 4'b0100, 0, 0, 0, 0,     "R9 suspended after entry");
    issue(0, 0, 1, 0, 1, 2, 0,       7, 0, 4'b0000, 0, 0, 0, 0,     "R5 precharge bank2");
    issue(0, 0, 0, 1, 0, 0, 0,      10, 0, 4'b0000, 1, 0, 0, 0,     "R7 entry");
    issue(0, 0, 1, 1, 0, 0, 'h0AA,  14, 0, 4'b0000, 1, 0, 0, 0,     "R7 activate ignored");
    issue(0, 1, 0, 1, 0, 1, 0,      14, 0, 4'b0000, 1, 0, 0, 0,     "R7 read ignored");
    issue(0, 1, 1, 1, 1, 0, 0,      11, 0, 4'b0000, 0, 0, 0, 0,     "R7 exit");
    issue(0, 0, 1, 1, 1, 0, 'h0F0,   2, 0, 4'b0001, 0, 1, 0, 'h0F0, "R2 activate after exit");
    issue(0, 1, 1, 1, 1, 0, 0,       0, 0, 4'b0001, 0, 0, 0, 0,     "R10 final nop");
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule